// File: doc/BRIEF.md
# Software Reset Request Controller

This block is a 32-bit reset request register for a microcontroller subsystem. Software writes a word, and every 1 in that word asks for a reset of one peripheral domain. The domain's reset output is then driven high for a fixed number of clock cycles. While the domain is in reset, its bit reads back as 1. When the hold time ends, the bit clears by itself. Writing 0 never cancels a reset that is already running.

Three group bits fan out to sets of domains:

- The soft bit resets every peripheral domain except the watchdog. It leaves the CPU alone.
- The peripheral bit also spares both GPIO banks.
- The system bit resets every domain, including the watchdog, and also drives the CPU reset output.

A group bit stays set until every domain it covers has finished. While the system reset is running, the register accepts no writes, so the register always reads all zeros once that reset completes.

Each domain has its own small channel state machine with states `CH_IDLE` and `CH_HOLD`:

- IDLE to HOLD happens on a start request.
- HOLD to HOLD happens while the counter is non-zero, or when the domain is restarted.
- HOLD to IDLE happens when the counter reaches zero.

Each group has a tracker with states `GR_IDLE` and `GR_WAIT`:

- IDLE to WAIT happens on the group's write.
- WAIT to IDLE happens when no covered domain will still be busy in the next cycle.

Top module: `swrst_ctrl`

## Requirements
- R1: After reset, `rd_data`, `dom_rst_o` and `cpu_rst_o` are all zero.
- R2: A write with bit b set, for b a domain position, drives `dom_rst_o[b]` and `rd_data[b]` to 1 from the cycle after the write. The domain positions are 0 (DMA), 1 (watchdog), 2 and 3 (GPIO banks), 5 to 8 (timers), 11 and 12 (UART0/1), 13 to 15 (SPI), 16 (I2C), 17 (RTC), 24 (random generator) and 28 (UART2).
- R3: A started domain stays in reset for exactly HOLD_CYC cycles (default 8), then clears on its own.
- R4: Writing 0 to a busy bit has no effect. Writes to the reserved positions 4, 9, 10, 18 to 23 and 25 to 27 are ignored: those bits always read 0 and never drive an output.
- R5: Writing 1 to a bit that is already busy restarts its hold time, so the domain is busy for HOLD_CYC cycles after the latest write.
- R6: Bit 29 (soft) resets all domains except the watchdog (bit 1) and leaves `cpu_rst_o` low.
- R7: Bit 30 (peripheral) resets all domains except the watchdog and the GPIO banks (bits 2 and 3), and leaves `cpu_rst_o` low.
- R8: Bit 31 (system) resets all domains and drives `cpu_rst_o` for the same window.
- R9: A group bit reads 1 until the last domain it covers has finished, and it clears in that same cycle. A domain that is not covered by the group does not hold the group bit. A group write restarts covered domains that are already busy.
- R10: While the system bit is busy, every write is ignored. In the cycle after it clears, `rd_data` is zero, and writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the request register |
| wr_data | input | 32 | Write data; each 1 requests a reset |
| rd_data | output | 32 | Busy bits of domains and groups |
| dom_rst_o | output | 32 | Per-domain reset outputs at their register positions |
| cpu_rst_o | output | 1 | CPU core reset, driven only by the system bit |

## Verification
Two requests can land on the same domain within one hold window: an individual bit and a group bit. This is provoked in three ways:

- an individual request followed by a covering group write;
- an individual request for the uncovered watchdog issued while the soft group runs;
- a system reset hit by writes in mid-window.

The bench predicts each read-back word cycle by cycle from the write times. It checks three things: the restarted domain's window is extended, the group bit clears with its last covered domain and not with a foreign one, and writes during a system reset leave no trace.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

    localparam int REG_W = 32;

    // Register positions that carry a resettable domain.
    localparam logic [REG_W-1:0] DOM_MASK  = 32'h1103_F9EF;
    localparam logic [REG_W-1:0] WDOG_MASK = 32'h0000_0002;
    localparam logic [REG_W-1:0] PIN_MASK  = 32'h0000_000C;

    localparam int NGRP     = 3;
    localparam int GRP_BASE = 29;   // soft, peripheral, system in ascending order
    localparam int SYS_GRP  = 2;

    typedef enum logic {CH_IDLE, CH_HOLD} ch_state_e;
    typedef enum logic {GR_IDLE, GR_WAIT} gr_state_e;

    function automatic logic [REG_W-1:0] grp_cover(input int g);
        logic [REG_W-1:0] m;
        unique case (g)
            0:       m = DOM_MASK & ~WDOG_MASK;
            1:       m = DOM_MASK & ~(WDOG_MASK | PIN_MASK);
            default: m = DOM_MASK;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/swrst_chan.sv
module swrst_chan #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic busy_nxt
);
    import swrst_pkg::*;

    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    ch_state_e       st_q, st_d;
    logic [CW-1:0]   cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (start) st_d = CH_HOLD;
            CH_HOLD: if (!start && cnt_q == '0) st_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (start)             cnt_q <= LAST;
        else if (st_q == CH_HOLD && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        busy     = (st_q == CH_HOLD);
        busy_nxt = (st_d == CH_HOLD);
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && cnt_q == LAST);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt_q != '0 |=> busy);
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cnt_q) == '0 && !$past(start));

endmodule

// File: rtl/swrst_group.sv
module swrst_group (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cover_nxt,
    output logic busy
);
    import swrst_pkg::*;

    gr_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GR_IDLE: if (go) st_d = GR_WAIT;
            GR_WAIT: if (!go && !cover_nxt) st_d = GR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GR_IDLE;
        else        st_q <= st_d;
    end

    always_comb busy = (st_q == GR_WAIT);

    p_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    p_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cover_nxt |=> busy);

endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl #(
    parameter int HOLD_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic [31:0] dom_rst_o,
    output logic        cpu_rst_o
);
    import swrst_pkg::*;

    logic             accept;
    logic [NGRP-1:0]  grp_go, grp_busy, grp_cnxt;
    logic [REG_W-1:0] dom_start, dom_busy, dom_nxt;
    logic             cpu_busy, cpu_nxt;

    always_comb accept = wr_en && !grp_busy[SYS_GRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [REG_W-1:0] COV = grp_cover(g);
        always_comb begin
            grp_go[g]   = accept && wr_data[GRP_BASE + g];
            grp_cnxt[g] = |(dom_nxt & COV) || (g == SYS_GRP && cpu_nxt);
        end
        swrst_group u_grp (
            .clk(clk), .rst_n(rst_n), .go(grp_go[g]),
            .cover_nxt(grp_cnxt[g]), .busy(grp_busy[g])
        );
        p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grp_busy[g]) |-> (dom_busy & COV) == '0);
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_dom
        if (DOM_MASK[i]) begin : g_live
            always_comb begin
                dom_start[i] = (accept && wr_data[i])
                             || (grp_go[0] && grp_cover(0)[i])
                             || (grp_go[1] && grp_cover(1)[i])
                             || (grp_go[2] && grp_cover(2)[i]);
            end
            swrst_chan #(.HOLD_CYC(HOLD_CYC)) u_chan (
                .clk(clk), .rst_n(rst_n), .start(dom_start[i]),
                .busy(dom_busy[i]), .busy_nxt(dom_nxt[i])
            );
        end else begin : g_rsvd
            always_comb begin
                dom_start[i] = 1'b0;
                dom_busy[i]  = 1'b0;
                dom_nxt[i]   = 1'b0;
            end
        end
    end

    swrst_chan #(.HOLD_CYC(HOLD_CYC)) u_cpu (
        .clk(clk), .rst_n(rst_n), .start(grp_go[SYS_GRP]),
        .busy(cpu_busy), .busy_nxt(cpu_nxt)
    );

    always_comb begin
        rd_data   = dom_busy | {grp_busy, {GRP_BASE{1'b0}}};
        dom_rst_o = dom_busy;
        cpu_rst_o = cpu_busy;
    end

    p_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_busy[0]) |-> (dom_busy & grp_cover(0)) == grp_cover(0));
    p_peri_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_busy[1]) |-> (dom_busy & grp_cover(1)) == grp_cover(1));
    p_sys_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_busy[SYS_GRP]) |-> cpu_rst_o && dom_busy == DOM_MASK);
    p_sys_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grp_busy[SYS_GRP]) |-> rd_data == '0 && !cpu_rst_o);

endmodule

// File: tb/sim_swrst_ctrl.sv
module sim_swrst_ctrl;

    localparam logic [31:0] DOM  = 32'h1103_F9EF;
    localparam logic [31:0] SOFT = 32'h2000_0000 | (DOM & ~32'h2);
    localparam logic [31:0] PERI = 32'h4000_0000 | (DOM & ~32'hE);
    localparam logic [31:0] SYSM = 32'h8000_0000 | DOM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, dom_rst_o;
    logic        cpu_rst_o;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    swrst_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .dom_rst_o(dom_rst_o), .cpu_rst_o(cpu_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Check all outputs at the current negedge, then move to the next one.
    task automatic step(input string tag, input logic [31:0] rd, input logic cpu);
        chk(tag, rd_data, rd);
        chk(tag, dom_rst_o, rd & DOM);
        chk(tag, {31'b0, cpu_rst_o}, {31'b0, cpu});
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] exp_of(input int b);
        if (b == 29) return SOFT;
        if (b == 30) return PERI;
        if (b == 31) return SYSM;
        return DOM[b] ? (32'h1 << b) : 32'h0;
    endfunction

    function automatic string tag_of(input int b);
        if (b == 29) return "R6";
        if (b == 30) return "R7";
        if (b == 31) return "R8";
        return DOM[b] ? "R2" : "R4";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        step("R1", 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1", 32'h0, 1'b0);

        // Sweep every register position alone: window of 8 then clear (R2..R8, R3)
        for (int b = 0; b < 32; b++) begin
            wr(32'h1 << b);
            for (int m = 0; m < 8; m++) step(tag_of(b), exp_of(b), b == 31);
            step("R3", 32'h0, 1'b0);
        end

        // R4: writing 0 to a busy bit, and writing all reserved bits
        wr(32'h1);
        step("R4", 32'h1, 1'b0);
        step("R4", 32'h1, 1'b0);
        wr(32'h0);
        for (int m = 3; m < 8; m++) step("R4", 32'h1, 1'b0);
        step("R4", 32'h0, 1'b0);
        wr(32'h0EFC_0610);
        step("R4", 32'h0, 1'b0);

        // R5: restart of a busy domain
        wr(32'h1);
        for (int m = 0; m < 3; m++) step("R5", 32'h1, 1'b0);
        wr(32'h1);
        for (int m = 0; m < 8; m++) step("R5", 32'h1, 1'b0);
        step("R5", 32'h0, 1'b0);

        // R9: group write restarts a busy covered domain
        wr(32'h1);
        for (int m = 0; m < 4; m++) step("R9", 32'h1, 1'b0);
        wr(32'h2000_0000);
        for (int m = 0; m < 8; m++) step("R9", SOFT, 1'b0);
        step("R9", 32'h0, 1'b0);

        // R9: uncovered watchdog does not hold the soft bit
        wr(32'h2000_0000);
        for (int m = 0; m < 3; m++) step("R9", SOFT, 1'b0);
        wr(32'h2);
        for (int m = 4; m < 8; m++) step("R9", SOFT | 32'h2, 1'b0);
        for (int m = 4; m < 8; m++) step("R9", 32'h2, 1'b0);
        step("R9", 32'h0, 1'b0);

        // R10: writes ignored during system reset, then accepted again
        wr(32'h8000_0000);
        step("R10", SYSM, 1'b1);
        step("R10", SYSM, 1'b1);
        wr(32'h2000_0001);
        for (int m = 3; m < 8; m++) step("R10", SYSM, 1'b1);
        step("R10", 32'h0, 1'b0);
        wr(32'h1);
        step("R10", 32'h1, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule